// File: doc/BRIEF.md
# DMA Channel Event and Region Interrupt Controller

This block keeps three kinds of per-channel state for a 64-channel DMA channel controller. The first is a latched hardware event bit. The second is an event-enable bit. The third is a completion-pending bit, which has its own interrupt-enable mask. Each 64-bit vector appears on a 32-bit register bus as two words: a low word for channels 0–31 and a high word for channels 32–63. Software never writes a state vector directly. It changes the state through companion registers, where writing a 1 sets or clears a bit and writing a 0 does nothing.

The same register set can be reached through a global view and through one view per shadow region. Each region has an access mask, programmed only from the global view. In a region's view, writes reach only the channels that mask enables, and reads return 0 for every other channel. The access mask also selects which completion codes drive that region's interrupt line. When two masks overlap, one completion raises several region interrupts. A pending-event vector goes to a downstream arbiter. A grant from the arbiter consumes the event bit of the granted channel.

Top module: `dmaev_ctrl`

## Requirements
- R1: After reset every state bit and every access mask is 0. `evt_pend`, `region_irq` and `bus_rvalid` are all low, and every register reads 0.
- R2: The address is split as {view, index[4:0]}. View 0 is global and view k+1 is shadow region k. An odd index selects channels 32–63 and an even index selects channels 0–31. The index map is: 0/1 event (read), 2/3 event-clear, 4/5 enable (read), 6/7 enable-set, 8/9 enable-clear, 10/11 pending (read), 12/13 pending-clear, 14/15 interrupt-enable (read), 16/17 interrupt-enable-set, 18/19 interrupt-enable-clear, 24+2k/25+2k access mask of region k. A write takes effect at the next clock edge. A read returns its word in `bus_rdata` with `bus_rvalid` high in the following cycle, and back-to-back reads are accepted on every cycle.
- R3: A pulse on `hw_evt[i]` sets event bit i. Writing 1 to event-clear bit i clears it, and writing 0 has no effect. If a pulse and a clear for the same channel fall in the same cycle, the bit ends up set.
- R4: Writing 1 to enable-set bit i sets enable bit i. Writing 1 to enable-clear bit i clears it. Zero bits change nothing.
- R5: `evt_pend[i]` is high exactly when event bit i and enable bit i are both 1. A cycle with `grant_valid` high and `grant_ch`=i clears event bit i, unless `hw_evt[i]` pulses in that same cycle.
- R6: A cycle with `cmpl_valid` high sets pending bit `cmpl_code`. Writing 1 to pending-clear clears pending bits. A completion and a clear of the same bit in the same cycle leave the bit set.
- R7: Writing 1 to interrupt-enable-set sets interrupt-enable bits, and writing 1 to interrupt-enable-clear clears them.
- R8: Access mask k is loaded directly by a global-view write to index 24+2k (channels 0–31) or 25+2k (channels 32–63), and it reads back unchanged.
- R9: In the view of region k, writes change only the channels set in mask k, and reads return 0 for every other channel. In a region view, the mask indices read 0 and ignore writes.
- R10: `region_irq[k]` is level-high while some channel has its pending bit, its interrupt-enable bit and its mask-k bit all set. With overlapping masks, one completion raises every region whose mask covers that code.
- R11: Writes to read-only indices, to indices 20–23, or to a view above the number of regions are ignored. Reads of those locations, and reads of the write-only indices, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | {view, register index} |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after request) |
| bus_rdata | output | 32 | Read data |
| hw_evt | input | 64 | Hardware event pulses, one per channel |
| grant_valid | input | 1 | Arbiter accepted a channel |
| grant_ch | input | 6 | Accepted channel number |
| cmpl_valid | input | 1 | Transfer completion this cycle |
| cmpl_code | input | 6 | Completion code of that transfer |
| evt_pend | output | 64 | Enabled pending events toward the arbiter |
| region_irq | output | NUM_REGIONS (4) | Completion interrupt per shadow region |

## Verification
The hardest situation to reach is a region interrupt that depends on three registers at once. It needs a pending bit from a completion, an interrupt-enable bit set through a companion register, and two overlapping region masks that can only be loaded from the global view. A shadow-view write must then be shown to affect only the bits in that region's mask. The stimulus first loads overlapping masks through the global view. It then enables the interrupt and issues completions whose codes fall in the overlap, in one region only, and in no region. It also collides completions with clears, and grants with fresh event pulses, in the same cycle. A long random phase follows, mixing all five inputs across every view and index. A behavioural model is compared with the design on every clock throughout.

// File: rtl/dmaev_pkg.sv
package dmaev_pkg;

    parameter int WORD_W = 32;
    parameter int CH_N   = 2 * WORD_W;
    parameter int CH_W   = $clog2(CH_N);
    parameter int IDX_W  = 5;
    parameter int PAIR_W = IDX_W - 1;

    // Register pair numbers (index = 2*pair + high-word flag)
    localparam logic [PAIR_W-1:0] P_EVT   = 4'd0;
    localparam logic [PAIR_W-1:0] P_EVCLR = 4'd1;
    localparam logic [PAIR_W-1:0] P_EN    = 4'd2;
    localparam logic [PAIR_W-1:0] P_ENSET = 4'd3;
    localparam logic [PAIR_W-1:0] P_ENCLR = 4'd4;
    localparam logic [PAIR_W-1:0] P_IP    = 4'd5;
    localparam logic [PAIR_W-1:0] P_IPCLR = 4'd6;
    localparam logic [PAIR_W-1:0] P_IE    = 4'd7;
    localparam logic [PAIR_W-1:0] P_IESET = 4'd8;
    localparam logic [PAIR_W-1:0] P_IECLR = 4'd9;
    localparam int                P_RMASK0 = 12;
    localparam int                MAX_REGIONS = (1 << PAIR_W) - P_RMASK0;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

endpackage

// File: rtl/dmaev_bit_reg.sv
module dmaev_bit_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    // Set has priority over clear within a cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_i) | set_i;
        end
    end

    AST_CLEAR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q_o) & ~q_o) & ~$past(clr_i)) == '0); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(set_i) & ~q_o) == '0)); // R6

endmodule

// File: rtl/dmaev_bus_fsm.sv
module dmaev_bus_fsm
    import dmaev_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       rd_word,
    output logic                    wr_stb,
    output logic [ADDR_W-IDX_W-1:0] view,
    output logic [PAIR_W-1:0]       pair,
    output logic                    hi,
    output logic                    bus_rvalid,
    output logic [WORD_W-1:0]       bus_rdata
);

    bus_state_e state_q, state_d;
    logic       rd_req;

    assign rd_req = bus_valid && !bus_write;
    assign wr_stb = bus_valid && bus_write;
    assign view   = bus_addr[ADDR_W-1:IDX_W];
    assign pair   = bus_addr[IDX_W-1:1];
    assign hi     = bus_addr[0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_req)  state_d = BUS_RESP;
            BUS_RESP: if (!rd_req) state_d = BUS_IDLE;
            default:               state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_req) begin
            bus_rdata <= rd_word;
        end
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
    end

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid); // R2

    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write)); // R2

endmodule

// File: rtl/dmaev_irq_fanout.sv
module dmaev_irq_fanout #(
    parameter int W       = 64,
    parameter int REGIONS = 4
) (
    input  logic [W-1:0]         ip_i,
    input  logic [W-1:0]         ie_i,
    input  logic [REGIONS*W-1:0] rmask_i,
    output logic [REGIONS-1:0]   irq_o
);

    logic [W-1:0] live;
    assign live = ip_i & ie_i;

    for (genvar k = 0; k < REGIONS; k++) begin : g_region
        assign irq_o[k] = |(live & rmask_i[k*W +: W]);
    end

endmodule

// File: rtl/dmaev_ctrl.sv
module dmaev_ctrl
    import dmaev_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = IDX_W + $clog2(NUM_REGIONS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic                   bus_rvalid,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [CH_N-1:0]        hw_evt,
    input  logic                   grant_valid,
    input  logic [CH_W-1:0]        grant_ch,
    input  logic                   cmpl_valid,
    input  logic [CH_W-1:0]        cmpl_code,
    output logic [CH_N-1:0]        evt_pend,
    output logic [NUM_REGIONS-1:0] region_irq
);

    localparam int              VIEW_W = ADDR_W - IDX_W;
    localparam logic [CH_N-1:0] ONE    = {{(CH_N-1){1'b0}}, 1'b1};
    localparam logic [CH_N-1:0] LO_SEL = {{WORD_W{1'b0}}, {WORD_W{1'b1}}};

    logic                     wr_stb, hi, wr_ok, view_ok, view_glb;
    logic [VIEW_W-1:0]        view;
    logic [PAIR_W-1:0]        pair;
    logic [CH_N-1:0]          ev_q, en_q, ip_q, ie_q;
    logic [NUM_REGIONS*CH_N-1:0] rmask_flat;
    logic [CH_N-1:0]          acc_mask, wvec, wsel, word_sel;
    logic [CH_N-1:0]          ev_clr, en_set, en_clr, ip_set, ip_clr, ie_set, ie_clr;
    logic [CH_N-1:0]          rd_src, rd_vis;
    logic [WORD_W-1:0]        rd_word, acc_word;

    dmaev_bus_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .rd_word    (rd_word),
        .wr_stb     (wr_stb),
        .view       (view),
        .pair       (pair),
        .hi         (hi),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata)
    );

    // View decode: global sees everything, region k sees its mask, others nothing
    always_comb begin
        view_glb = (view == '0);
        view_ok  = view_glb;
        acc_mask = view_glb ? '1 : '0;
        for (int k = 0; k < NUM_REGIONS; k++) begin
            if (view == VIEW_W'(k + 1)) begin
                view_ok  = 1'b1;
                acc_mask = rmask_flat[k*CH_N +: CH_N];
            end
        end
    end

    assign word_sel = hi ? ~LO_SEL : LO_SEL;
    assign wvec     = hi ? {bus_wdata, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, bus_wdata};
    assign wsel     = wvec & acc_mask;
    assign wr_ok    = wr_stb && view_ok;
    assign acc_word = hi ? acc_mask[CH_N-1:WORD_W] : acc_mask[WORD_W-1:0];

    // Companion-register strobes
    assign ev_clr = ((wr_ok && pair == P_EVCLR) ? wsel : '0)
                  | (grant_valid ? (ONE << grant_ch) : '0);
    assign en_set = (wr_ok && pair == P_ENSET) ? wsel : '0;
    assign en_clr = (wr_ok && pair == P_ENCLR) ? wsel : '0;
    assign ip_set = cmpl_valid ? (ONE << cmpl_code) : '0;
    assign ip_clr = (wr_ok && pair == P_IPCLR) ? wsel : '0;
    assign ie_set = (wr_ok && pair == P_IESET) ? wsel : '0;
    assign ie_clr = (wr_ok && pair == P_IECLR) ? wsel : '0;

    dmaev_bit_reg #(.W(CH_N)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_i(hw_evt), .clr_i(ev_clr), .q_o(ev_q));
    dmaev_bit_reg #(.W(CH_N)) u_en (
        .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .q_o(en_q));
    dmaev_bit_reg #(.W(CH_N)) u_ip (
        .clk(clk), .rst_n(rst_n), .set_i(ip_set), .clr_i(ip_clr), .q_o(ip_q));
    dmaev_bit_reg #(.W(CH_N)) u_ie (
        .clk(clk), .rst_n(rst_n), .set_i(ie_set), .clr_i(ie_clr), .q_o(ie_q));

    // Region access masks: a load is clear-word plus set-data
    for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_rmask
        logic hit;
        assign hit = wr_stb && view_glb && (pair == PAIR_W'(P_RMASK0 + k));
        dmaev_bit_reg #(.W(CH_N)) u_mask (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (hit ? wvec : '0),
            .clr_i (hit ? word_sel : '0),
            .q_o   (rmask_flat[k*CH_N +: CH_N])
        );
    end

    // Read mux
    always_comb begin
        case (pair)
            P_EVT:   rd_src = ev_q;
            P_EN:    rd_src = en_q;
            P_IP:    rd_src = ip_q;
            P_IE:    rd_src = ie_q;
            default: rd_src = '0;
        endcase
        for (int k = 0; k < NUM_REGIONS; k++) begin
            if (view_glb && pair == PAIR_W'(P_RMASK0 + k)) begin
                rd_src = rmask_flat[k*CH_N +: CH_N];
            end
        end
    end

    assign rd_vis  = view_ok ? (rd_src & acc_mask) : '0;
    assign rd_word = hi ? rd_vis[CH_N-1:WORD_W] : rd_vis[WORD_W-1:0];

    assign evt_pend = ev_q & en_q;

    dmaev_irq_fanout #(.W(CH_N), .REGIONS(NUM_REGIONS)) u_irq (
        .ip_i    (ip_q),
        .ie_i    (ie_q),
        .rmask_i (rmask_flat),
        .irq_o   (region_irq)
    );

    AST_GRANT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !hw_evt[grant_ch]) |=> !evt_pend[$past(grant_ch)]); // R5

    AST_CMPL_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> ip_q[$past(cmpl_code)]); // R6

    AST_SHADOW_READ_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && view != '0) |=> ((bus_rdata & ~$past(acc_word)) == '0)); // R9

    for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_chk
        AST_FANOUT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (cmpl_valid && ie_q[cmpl_code] && rmask_flat[k*CH_N + int'(cmpl_code)]
             && !(bus_valid && bus_write)) |=> region_irq[k]); // R10
    end

endmodule

// File: tb/dmaev_ctrl_tb_top.sv
module dmaev_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NREG = 4;
    localparam int AW   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [63:0] hw_evt = '0;
    logic        grant_valid = 1'b0;
    logic [5:0]  grant_ch = '0;
    logic        cmpl_valid = 1'b0;
    logic [5:0]  cmpl_code = '0;
    logic [63:0] evt_pend;
    logic [NREG-1:0] region_irq;

    always #2.5 clk = ~clk;

    dmaev_ctrl #(.NUM_REGIONS(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .hw_evt(hw_evt), .grant_valid(grant_valid), .grant_ch(grant_ch),
        .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
        .evt_pend(evt_pend), .region_irq(region_irq)
    );

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    bit    done    = 0;

    // Behavioural reference model
    bit [63:0] m_ev, m_en, m_ip, m_ie;
    bit [63:0] m_rm [NREG];
    bit        m_rvalid;
    bit [31:0] m_rdata;

    function automatic bit [31:0] model_read(int v, int p, bit h, bit [63:0] am);
        bit [63:0] src;
        src = 64'h0;
        if (v > NREG) return 32'h0;
        case (p)
            0: src = m_ev;
            2: src = m_en;
            5: src = m_ip;
            7: src = m_ie;
            default: if (p >= 12 && v == 0 && (p - 12) < NREG) src = m_rm[p-12];
        endcase
        src = src & am;
        return h ? src[63:32] : src[31:0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int v, p;
        bit h;
        bit [63:0] am, wv, evc, ipc;
        if (!rst_n) begin
            m_ev = 0; m_en = 0; m_ip = 0; m_ie = 0;
            for (int k = 0; k < NREG; k++) m_rm[k] = 0;
            m_rvalid = 0; m_rdata = 0;
        end else begin
            v = int'(bus_addr) / 32;
            p = (int'(bus_addr) % 32) / 2;
            h = bus_addr[0];
            am = 64'h0;
            if (v == 0) am = '1;
            else if (v <= NREG) am = m_rm[v-1];
            wv = h ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};
            wv = wv & am;
            m_rvalid = bus_valid && !bus_write;
            if (m_rvalid) m_rdata = model_read(v, p, h, am);
            evc = grant_valid ? (64'd1 << grant_ch) : 64'h0;
            ipc = 64'h0;
            if (bus_valid && bus_write && v <= NREG) begin
                case (p)
                    1: evc = evc | wv;
                    3: m_en = m_en | wv;
                    4: m_en = m_en & ~wv;
                    6: ipc = wv;
                    8: m_ie = m_ie | wv;
                    9: m_ie = m_ie & ~wv;
                    default: if (v == 0 && p >= 12 && (p - 12) < NREG) begin
                        if (h) m_rm[p-12][63:32] = bus_wdata;
                        else   m_rm[p-12][31:0]  = bus_wdata;
                    end
                endcase
            end
            m_ev = (m_ev & ~evc) | hw_evt;
            m_ip = (m_ip & ~ipc) | (cmpl_valid ? (64'd1 << cmpl_code) : 64'h0);
        end
    end

    task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                cmp(evt_pend, 64'h0, "R1 evt_pend in reset");
                cmp(64'(region_irq), 64'h0, "R1 region_irq in reset");
                cmp(64'(bus_rvalid), 64'h0, "R1 rvalid in reset");
            end else begin
                cmp(64'(bus_rvalid), 64'(m_rvalid), "R2 rvalid");
                if (m_rvalid) cmp(64'(bus_rdata), 64'(m_rdata), "R2 rdata");
                cmp(evt_pend, m_ev & m_en, "R5 evt_pend");
                for (int k = 0; k < NREG; k++)
                    cmp(64'(region_irq[k]), 64'(|(m_ip & m_ie & m_rm[k])), "R10 region_irq");
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        hw_evt = '0; grant_valid = 0; grant_ch = '0; cmpl_valid = 0; cmpl_code = '0;
    endtask

    task automatic wr(input int v, input int idx, input logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = AW'(v * 32 + idx); bus_wdata = d;
        tick();
        clear_in();
    endtask

    task automatic rd(input int v, input int idx);
        bus_valid = 1; bus_write = 0; bus_addr = AW'(v * 32 + idx);
        tick();
        clear_in();
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        tick();
        // R1: everything reads zero after reset
        cur_req = "R1";
        rd(0, 0); rd(0, 5); rd(0, 10); rd(0, 15); rd(0, 24); rd(0, 31);
        idle(2);

        // R3: event set by pulse, cleared only by ones in event-clear
        cur_req = "R3";
        hw_evt = 64'h8000_0002_0000_0021; tick(); clear_in();
        rd(0, 0); rd(0, 1);
        wr(0, 2, 32'h0); rd(0, 0);
        wr(0, 2, 32'h1); rd(0, 0);
        hw_evt[5] = 1'b1; bus_valid = 1; bus_write = 1; bus_addr = 8'd2; bus_wdata = 32'h20;
        tick(); clear_in();
        rd(0, 0);
        wr(0, 3, 32'h0000_0002); rd(0, 1);

        // R4: enable set / clear companions
        cur_req = "R4";
        wr(0, 6, 32'h0000_0021); wr(0, 7, 32'h8000_0000);
        rd(0, 4); rd(0, 5);
        wr(0, 8, 32'h0); rd(0, 4);
        wr(0, 8, 32'h1); rd(0, 4);

        // R5: pending output and grant consumption
        cur_req = "R5";
        hw_evt = 64'h8000_0000_0000_0021; tick(); clear_in();
        idle(1);
        grant_valid = 1; grant_ch = 6'd5; tick(); clear_in();
        idle(1);
        grant_valid = 1; grant_ch = 6'd63; hw_evt[63] = 1'b1; tick(); clear_in();
        idle(1);
        grant_valid = 1; grant_ch = 6'd63; tick(); clear_in();
        rd(0, 0); rd(0, 1);

        // R6: completion sets pending, clear companion, set wins
        cur_req = "R6";
        cmpl_valid = 1; cmpl_code = 6'd3; tick(); clear_in();
        cmpl_valid = 1; cmpl_code = 6'd40; tick(); clear_in();
        rd(0, 10); rd(0, 11);
        wr(0, 12, 32'h0); rd(0, 10);
        cmpl_valid = 1; cmpl_code = 6'd3; bus_valid = 1; bus_write = 1; bus_addr = 8'd12; bus_wdata = 32'h8;
        tick(); clear_in();
        rd(0, 10);
        wr(0, 13, 32'h100); rd(0, 11);

        // R7: interrupt-enable companions
        cur_req = "R7";
        wr(0, 16, 32'h8); wr(0, 17, 32'h100);
        rd(0, 14); rd(0, 15);
        wr(0, 18, 32'h8); rd(0, 14);
        wr(0, 16, 32'h8);

        // R8: access masks load and read back (overlap on channel 3)
        cur_req = "R8";
        wr(0, 24, 32'h0000_00FF); wr(0, 25, 32'h0000_0001);
        wr(0, 26, 32'h0000_0F0F);
        wr(0, 29, 32'h0000_0100);
        wr(0, 30, 32'hA5A5_0000);
        for (int i = 24; i < 32; i++) rd(0, i);

        // R9: shadow views filter writes and reads
        cur_req = "R9";
        wr(1, 6, 32'hFFFF_FFFF);
        rd(0, 4); rd(1, 4); rd(2, 4); rd(3, 4); rd(3, 5);
        wr(2, 8, 32'hFFFF_FFFF); rd(0, 4);
        rd(1, 24); rd(2, 26);
        wr(1, 24, 32'h0); rd(0, 24);
        hw_evt = 64'hFFFF_FFFF_FFFF_FFFF; tick(); clear_in();
        wr(3, 3, 32'hFFFF_FFFF); rd(0, 1); rd(0, 0);

        // R10: region interrupt fan-out with overlapping masks
        cur_req = "R10";
        wr(0, 12, 32'hFFFF_FFFF); wr(0, 13, 32'hFFFF_FFFF);
        idle(1);
        cmpl_valid = 1; cmpl_code = 6'd3; tick(); clear_in();
        idle(2);
        wr(1, 12, 32'h8);
        idle(1);
        cmpl_valid = 1; cmpl_code = 6'd40; tick(); clear_in();
        idle(1);
        wr(0, 17, 32'h100);
        idle(2);
        cmpl_valid = 1; cmpl_code = 6'd20; tick(); clear_in();
        idle(1);
        wr(0, 18, 32'hFFFF_FFFF); wr(0, 19, 32'hFFFF_FFFF);
        idle(1);

        // R11: unmapped indices and views
        cur_req = "R11";
        wr(0, 20, 32'hFFFF_FFFF); wr(0, 23, 32'hFFFF_FFFF);
        rd(0, 20); rd(0, 22); rd(0, 2); rd(0, 7);
        wr(5, 6, 32'hFFFF_FFFF); wr(7, 24, 32'hFFFF_FFFF);
        rd(5, 4); rd(6, 0); rd(0, 4); rd(0, 24);
        wr(0, 10, 32'hFFFF_FFFF); rd(0, 10);

        // R2: back-to-back reads and read directly after write
        cur_req = "R2";
        for (int i = 0; i < 8; i++) begin
            bus_valid = 1; bus_write = 0; bus_addr = AW'(24 + i); tick();
        end
        clear_in();
        wr(0, 6, 32'h0000_F000);
        rd(0, 4);
        idle(2);

        // Mixed random traffic over every view and index
        cur_req = "RND";
        for (int n = 0; n < 4000; n++) begin
            int op;
            op = int'($urandom % 4);
            hw_evt = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            grant_valid = $urandom % 2;
            grant_ch = 6'($urandom);
            cmpl_valid = ($urandom % 3) == 0;
            cmpl_code = 6'($urandom);
            if (op != 0) begin
                bus_valid = 1;
                bus_write = (op >= 2);
                bus_addr = AW'(($urandom % 6) * 32 + ($urandom % 32));
                bus_wdata = $urandom;
            end
            tick();
            clear_in();
        end
        idle(3);
        finish_run();
    end

endmodule